// File: doc/BRIEF.md
# Ternary-Match Microcode Entry Decoder

This block turns an instruction byte, plus its addressing byte where needed, into the first address of the microcode routine that handles it. The microcode store is split into chunks of four words. Each chunk owns one 11-bit pattern, and every bit of that pattern is a one, a zero or a don't-care. When the strobe is high, a key built from the inputs is compared against all patterns in the same cycle. The lowest-numbered chunk that matches supplies the start address, which is its index times four.

One structure serves four kinds of lookup, chosen by a 2-bit kind select: plain opcode dispatch, long-jump targets, subroutine targets and effective-address handlers. The group opcodes carry a sub-operation in the middle field of the addressing byte, and that field goes into their key. The start address is registered and reported one cycle after the strobe, together with either a hit pulse or a miss pulse. While reset is held, the output shows the reset entry point. The pattern table is fixed when the block is elaborated. The microcode store and the sequencer are outside this block.

Top module: `ucd_entry_decoder`

## Requirements
- R1: With kind 00 and an opcode other than F6, F7, FE or FF, the key is {00, 1'b0, opcode}, and the addressing byte has no effect.
- R2: With kind 00 and opcode F6, F7, FE or FF, the key is {00, 1'b1, opcode[3], opcode[0], 3'b111, modrm[5:3]}.
- R3: With kind 01 (long jump) or 10 (subroutine), the key is {kind, 1'b0, opcode}. With kind 11 (effective address), the key is {11, 4'b0000, modrm[7:6], modrm[2:0]}.
- R4: Chunk i matches when ((key XOR value_i) AND care_i) is zero. A care bit of 0 makes that key bit a don't-care.
- R5: When several chunks match, the lowest index wins.
- R6: The reported start address is the winning chunk index shifted left by two, with the low two bits zero.
- R7: A strobe that hits gives valid high for exactly one cycle on the clock edge that follows, with the new address present in that same cycle.
- R8: A strobe that matches no chunk gives miss high for one cycle, keeps valid low and leaves the address unchanged.
- R9: With strobe low, valid and miss stay low on the next cycle and the address holds, whatever key is presented.
- R10: While reset is high (synchronous, active high), the address equals RESET_ADDR and valid and miss are low, even if the strobe is high. After reset is released, the address stays at RESET_ADDR until the first hit.
- R11: valid and miss are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Request a lookup this cycle |
| key_kind | input | 2 | 00 opcode, 01 long jump, 10 subroutine, 11 effective address |
| opcode | input | 8 | Instruction byte, or target tag for jump and subroutine lookups |
| modrm | input | 8 | Addressing byte |
| start_addr | output | IDX_W+2 | Registered microcode start address |
| valid | output | 1 | One-cycle pulse: a lookup hit |
| miss | output | 1 | One-cycle pulse: a lookup matched no chunk |

## Verification
The bench aims at overlapping patterns. A priority encoder that chose the highest index would send opcode 8A to the wider chunk's neighbour. The group opcodes F6 and F7 share the same sub-operation, and only a don't-care on the opcode's low bit tells their entries apart: a key former that dropped opcode[3] or opcode[0] would merge them, and one that left out the addressing field would send every member of a group to the same routine. The bench also sends the same 9-bit body under different kinds to show that the kind bits are part of the match. It checks that a miss, an idle cycle and a strobe held during reset all leave the address where it should be.

// File: rtl/ucd_pkg.sv
package ucd_pkg;

  localparam int KEY_W  = 11;
  localparam int BODY_W = 9;

  typedef enum logic [1:0] {
    KT_OPCODE = 2'b00,
    KT_JUMP   = 2'b01,
    KT_CALL   = 2'b10,
    KT_EADDR  = 2'b11
  } key_kind_e;

  typedef logic [KEY_W-1:0] key_t;

  // a group-style body with a zero middle field is never produced by key_body
  localparam key_t NEVER_VAL = 11'h100;
  localparam key_t FULL_CARE = 11'h7FF;

  // F6, F7, FE, FF: upper nibble F and bits 2:1 both set
  function automatic logic is_group_op(input logic [7:0] op);
    return (op[7:4] == 4'hF) && (op[2:1] == 2'b11);
  endfunction

  function automatic logic [BODY_W-1:0] key_body(input key_kind_e kind,
                                                 input logic [7:0] op,
                                                 input logic [7:0] mr);
    logic [BODY_W-1:0] body;
    unique case (kind)
      KT_OPCODE: begin
        if (is_group_op(op)) body = {1'b1, op[3], op[0], 3'b111, mr[5:3]};
        else                 body = {1'b0, op};
      end
      KT_EADDR:  body = {4'b0000, mr[7:6], mr[2:0]};
      default:   body = {1'b0, op};
    endcase
    return body;
  endfunction

  function automatic logic tern_hit(input key_t key, input key_t val, input key_t care);
    return ((key ^ val) & care) == '0;
  endfunction

endpackage

// File: rtl/ucd_key_former.sv
module ucd_key_former
  import ucd_pkg::*;
(
  input  logic [1:0] kind_sel,
  input  logic [7:0] opcode,
  input  logic [7:0] modrm,
  output key_t       key
);

  key_kind_e kind;

  assign kind = key_kind_e'(kind_sel);
  assign key  = {kind_sel, key_body(kind, opcode, modrm)};

endmodule

// File: rtl/ucd_match_array.sv
module ucd_match_array
  import ucd_pkg::*;
#(
  parameter int NUM_CHUNKS = 16,
  parameter logic [NUM_CHUNKS*KEY_W-1:0] PAT_VAL  = {NUM_CHUNKS{NEVER_VAL}},
  parameter logic [NUM_CHUNKS*KEY_W-1:0] PAT_CARE = {NUM_CHUNKS{FULL_CARE}}
) (
  input  key_t                  key,
  output logic [NUM_CHUNKS-1:0] match_vec
);

  // one comparator row per four-word chunk, all evaluated in parallel
  for (genvar g = 0; g < NUM_CHUNKS; g++) begin : g_row
    localparam key_t ROW_VAL  = PAT_VAL[g*KEY_W +: KEY_W];
    localparam key_t ROW_CARE = PAT_CARE[g*KEY_W +: KEY_W];
    assign match_vec[g] = tern_hit(key, ROW_VAL, ROW_CARE);
  end

endmodule

// File: rtl/ucd_prio_enc.sv
module ucd_prio_enc #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  // scan from the top so the lowest set bit is written last and wins
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign any = |req;

endmodule

// File: rtl/ucd_entry_decoder.sv
module ucd_entry_decoder
  import ucd_pkg::*;
#(
  parameter int NUM_CHUNKS = 16,
  parameter int unsigned RESET_ADDR = 0,
  parameter logic [NUM_CHUNKS*KEY_W-1:0] PAT_VAL  = {NUM_CHUNKS{NEVER_VAL}},
  parameter logic [NUM_CHUNKS*KEY_W-1:0] PAT_CARE = {NUM_CHUNKS{FULL_CARE}},
  localparam int IDX_W  = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1,
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [1:0]        key_kind,
  input  logic [7:0]        opcode,
  input  logic [7:0]        modrm,
  output logic [ADDR_W-1:0] start_addr,
  output logic              valid,
  output logic              miss
);

  key_t                  lookup_key;
  logic [NUM_CHUNKS-1:0] match_vec;
  logic                  any_hit;
  logic [IDX_W-1:0]      win_idx;
  logic                  take_hit;
  logic                  take_miss;

  ucd_key_former u_key (
    .kind_sel (key_kind),
    .opcode   (opcode),
    .modrm    (modrm),
    .key      (lookup_key)
  );

  ucd_match_array #(
    .NUM_CHUNKS (NUM_CHUNKS),
    .PAT_VAL    (PAT_VAL),
    .PAT_CARE   (PAT_CARE)
  ) u_match (
    .key       (lookup_key),
    .match_vec (match_vec)
  );

  ucd_prio_enc #(
    .N     (NUM_CHUNKS),
    .IDX_W (IDX_W)
  ) u_prio (
    .req (match_vec),
    .any (any_hit),
    .idx (win_idx)
  );

  assign take_hit  = strobe && any_hit;
  assign take_miss = strobe && !any_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_addr <= ADDR_W'(RESET_ADDR);
      valid      <= 1'b0;
      miss       <= 1'b0;
    end else begin
      valid <= take_hit;
      miss  <= take_miss;
      if (take_hit) start_addr <= {win_idx, 2'b00};
    end
  end

endmodule

// File: rtl/ucd_entry_checker.sv
module ucd_entry_checker #(
  parameter int NUM_CHUNKS = 16,
  parameter int unsigned RESET_ADDR = 0,
  localparam int IDX_W  = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1,
  localparam int ADDR_W = IDX_W + 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  strobe,
  input logic                  valid,
  input logic                  miss,
  input logic [ADDR_W-1:0]     start_addr,
  input logic [NUM_CHUNKS-1:0] match_vec,
  input logic                  any_hit,
  input logic [IDX_W-1:0]      win_idx
);

  logic [NUM_CHUNKS-1:0] below_win;
  assign below_win = ({{(NUM_CHUNKS-1){1'b0}}, 1'b1} << win_idx) - {{(NUM_CHUNKS-1){1'b0}}, 1'b1};

  assert_lowest_wins_R5: assert property (@(posedge clk) disable iff (rst)
    any_hit |-> (match_vec[win_idx] && ((match_vec & below_win) == '0)));

  assert_addr_from_index_R6: assert property (@(posedge clk) disable iff (rst)
    valid |-> (start_addr == {$past(win_idx), 2'b00}));

  assert_pulse_needs_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    (valid || miss) |-> $past(strobe));

  assert_miss_holds_addr_R8: assert property (@(posedge clk) disable iff (rst)
    miss |-> $stable(start_addr));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> (!valid && !miss));

  assert_reset_entry_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (start_addr == ADDR_W'(RESET_ADDR) && !valid && !miss));

  assert_hit_miss_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(valid && miss));

endmodule

bind ucd_entry_decoder ucd_entry_checker #(
  .NUM_CHUNKS (NUM_CHUNKS),
  .RESET_ADDR (RESET_ADDR)
) u_check (
  .clk        (clk),
  .rst        (rst),
  .strobe     (strobe),
  .valid      (valid),
  .miss       (miss),
  .start_addr (start_addr),
  .match_vec  (match_vec),
  .any_hit    (any_hit),
  .win_idx    (win_idx)
);

// File: tb/tb_ucd_entry_decoder.sv
module tb_ucd_entry_decoder;

  localparam int N      = 16;
  localparam int KW     = 11;
  localparam int AW     = 6;
  localparam int unsigned RST_A = 36;

  // chunk 15 first, chunk 0 last
  localparam logic [N*KW-1:0] TB_VAL = {11'h606, {6{11'h100}}, 11'h618, 11'h420, 11'h205,
                                        11'h1F8, 11'h13B, 11'h13B, 11'h088, 11'h080, 11'h090};
  localparam logic [N*KW-1:0] TB_CARE = {11'h7FF, {6{11'h7FF}}, 11'h7F8, 11'h7F0, 11'h7FF,
                                         11'h7F8, 11'h7BF, 11'h7FF, 11'h7F8, 11'h7F0, 11'h7FF};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          strobe = 1'b0;
  logic [1:0]    key_kind = 2'b00;
  logic [7:0]    opcode = 8'h00;
  logic [7:0]    modrm = 8'h00;
  logic [AW-1:0] start_addr;
  logic          valid;
  logic          miss;

  always #5 clk = ~clk;

  ucd_entry_decoder #(
    .NUM_CHUNKS (N),
    .RESET_ADDR (RST_A),
    .PAT_VAL    (TB_VAL),
    .PAT_CARE   (TB_CARE)
  ) dut (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .key_kind   (key_kind),
    .opcode     (opcode),
    .modrm      (modrm),
    .start_addr (start_addr),
    .valid      (valid),
    .miss       (miss)
  );

  typedef struct {
    logic          v;
    logic          m;
    logic [AW-1:0] a;
    string         tag;
  } exp_t;

  exp_t q[$];
  int compared = 0;
  int mismatched = 0;
  logic [AW-1:0] model_addr = AW'(RST_A);
  bit finished = 0;

  function automatic logic [KW-1:0] model_key(logic [1:0] k, logic [7:0] op, logic [7:0] mr);
    if (k == 2'b11) return {k, 4'b0000, mr[7:6], mr[2:0]};
    if (k == 2'b00 && (op == 8'hF6 || op == 8'hF7 || op == 8'hFE || op == 8'hFF))
      return {k, 1'b1, op[3], op[0], 3'b111, mr[5:3]};
    return {k, 1'b0, op};
  endfunction

  function automatic int model_find(logic [KW-1:0] key);
    for (int i = 0; i < N; i++) begin
      if (((key ^ TB_VAL[i*KW +: KW]) & TB_CARE[i*KW +: KW]) == '0) return i;
    end
    return -1;
  endfunction

  task automatic drive(input logic stb, input logic [1:0] k, input logic [7:0] op,
                       input logic [7:0] mr, input string tag);
    exp_t e;
    int hit;
    @(negedge clk);
    strobe = stb; key_kind = k; opcode = op; modrm = mr;
    hit = model_find(model_key(k, op, mr));
    e.tag = tag;
    e.v = stb && (hit >= 0);
    e.m = stb && (hit < 0);
    if (e.v) model_addr = AW'(hit * 4);
    e.a = model_addr;
    q.push_back(e);
  endtask

  task automatic drain();
    drive(1'b0, 2'b00, 8'h00, 8'h00, "R9 idle");
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic check_direct(input logic cond, input string tag, input logic [AW-1:0] exp_a);
    compared++;
    if (!cond) begin
      mismatched++;
      $display("FAIL %s: got v=%0b m=%0b a=%0d exp v=0 m=0 a=%0d", tag, valid, miss, start_addr, exp_a);
    end
  endtask

  // monitor: compares one expected item per cycle, after the edge settles
  always begin
    @(posedge clk);
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      compared++;
      if (valid !== e.v || miss !== e.m || start_addr !== e.a) begin
        mismatched++;
        $display("FAIL %s: got v=%0b m=%0b a=%0d exp v=%0b m=%0b a=%0d",
                 e.tag, valid, miss, start_addr, e.v, e.m, e.a);
      end
      compared++;
      if (valid && miss) begin
        mismatched++;
        $display("FAIL R11 %s: got v=1 m=1 exp not both", e.tag);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    compared++;
    mismatched++;
    $display("FAIL watchdog: got hung run exp completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check_direct(start_addr == AW'(RST_A) && !valid && !miss, "R10 reset state", AW'(RST_A));
    @(negedge clk);
    rst = 1'b0;
    drive(1'b0, 2'b00, 8'h90, 8'h00, "R10 R9 hold reset addr with idle hitting key");
    drive(1'b1, 2'b00, 8'h12, 8'h00, "R8 miss keeps reset addr");
    drive(1'b1, 2'b00, 8'h90, 8'hFF, "R1 R6 exact opcode, modrm ignored");
    drive(1'b0, 2'b00, 8'h00, 8'h00, "R7 valid lasts one cycle");
    drive(1'b1, 2'b00, 8'h8A, 8'h00, "R5 R4 overlap lowest wins");
    drive(1'b1, 2'b00, 8'h8F, 8'h3C, "R5 overlap upper end");
    drive(1'b1, 2'b00, 8'hF6, 8'h18, "R2 F6 reg3");
    drive(1'b1, 2'b00, 8'hF7, 8'hD8, "R2 R4 F7 reg3 via dont-care");
    drive(1'b1, 2'b00, 8'hFF, 8'h30, "R2 FF any reg");
    drive(1'b1, 2'b00, 8'hFE, 8'h10, "R2 R8 FE reg2 miss");
    drive(1'b1, 2'b00, 8'h05, 8'h00, "R3 R8 jump tag under opcode kind misses");
    drive(1'b1, 2'b01, 8'h05, 8'h00, "R3 long jump target");
    drive(1'b1, 2'b01, 8'h90, 8'h00, "R3 R8 kind bits are matched");
    drive(1'b1, 2'b10, 8'h2A, 8'h00, "R3 R4 subroutine range");
    drive(1'b1, 2'b10, 8'h30, 8'h00, "R3 R8 subroutine miss");
    drive(1'b1, 2'b11, 8'h00, 8'hC5, "R3 R4 eaddr mod11");
    drive(1'b1, 2'b11, 8'h77, 8'h06, "R3 R6 eaddr top chunk");
    drive(1'b1, 2'b11, 8'h00, 8'h3E, "R3 eaddr reg field ignored");
    drive(1'b1, 2'b11, 8'h00, 8'h46, "R3 R8 eaddr mod01 miss");
    drive(1'b0, 2'b00, 8'hF6, 8'h18, "R9 idle with hitting key");
    drive(1'b1, 2'b00, 8'h90, 8'h00, "R7 back to back hit 1");
    drive(1'b1, 2'b01, 8'h05, 8'h00, "R7 back to back hit 2");
    drain();
    @(negedge clk);
    rst = 1'b1; strobe = 1'b1; key_kind = 2'b00; opcode = 8'h90; modrm = 8'h00;
    @(posedge clk);
    #2;
    check_direct(start_addr == AW'(RST_A) && !valid && !miss, "R10 reset overrides strobe", AW'(RST_A));
    @(negedge clk);
    rst = 1'b0; strobe = 1'b0;
    model_addr = AW'(RST_A);
    drive(1'b0, 2'b00, 8'h00, 8'h00, "R10 after re-reset");
    drive(1'b1, 2'b00, 8'hF6, 8'h18, "R6 hit after re-reset");
    drain();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule